// File: doc/BRIEF.md
# Video Receiver Mode Lock Controller

This block decides lock status and output gating for a serial video receiver that takes SMPTE SD, SMPTE HD or DVB-ASI streams. A mode input picks one of two roles for four shared status lines. In master mode the block drives them as outputs that report the detected format. In slave mode it reads them as format controls and a loop-through select. The four lines are presented as separate input, output and output-enable vectors so that the pad ring can build the bidirectional buffers.

Parallel words enter on a valid/ready stream and leave on another one through a single register stage. A word that goes out while the block has no usable lock is replaced by zero. The output holds its word while `out_valid` is high and `out_ready` is low. `in_ready` is high whenever that register is empty or being emptied in the same cycle, so back-pressure reaches the source in the same cycle with no extra buffering.

Top module: `vid_lock_ctrl`

## Requirements
- R1: While `rst_n` is low at a clock edge, `locked`, `data_err_n`, `loop_reclk`, `pin_out`, `pin_oe`, `out_valid` and `out_data` are all cleared to zero.
- R2: `pin_oe` is all ones one clock after `master_mode` is sampled high and all zeros one clock after it is sampled low.
- R3: In master mode with PLL lock, the shared lines are bit 3 = SMPTE, bit 2 = ASI, bit 1 = SD rate, bit 0 = reclock. They report HD as 1001, SD as 1011 and ASI as 0111. `locked`, `data_err_n` and `loop_reclk` are high and words pass unchanged. The HD flag takes priority over the SD flag, and both take priority over ASI.
- R4: In master mode with PLL lock and no detector flag, `pin_out` is 0000, `locked` is low, `loop_reclk` is low (buffered loop-through), `data_err_n` is high and passed words are zero.
- R5: Without PLL lock, in either mode, `locked` and `data_err_n` are low, `pin_out` is 0000 and passed words are zero.
- R6: In slave mode with PLL lock, when `pin_in[3:1]` equals the code of the detected format (HD 100, SD 101, ASI 011), `locked` and `data_err_n` are high and words pass unchanged.
- R7: In slave mode with PLL lock, when `pin_in[3:1]` differs from the detected code in any bit and `pin_in[3:2]` is not 00, `locked` and `data_err_n` are low and passed words are zero.
- R8: In slave mode with PLL lock, `pin_in[3:2]` = 00 selects data-through. Words pass unchanged and `locked` and `data_err_n` are high, whatever the detectors report.
- R9: In slave mode, `loop_reclk` is `pin_in[0]` sampled at the previous edge, and `pin_out` is 0000.
- R10: At the edge where `pin_oe` rises from zero, `pin_out` is 0000. The format code appears one edge later, so `pin_out` is never non-zero while `pin_oe` is not all ones.
- R11: `in_ready` equals `!out_valid || out_ready`. While `out_valid` is high and `out_ready` low, `out_data` and `out_valid` hold. Every accepted word leaves exactly once, in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| master_mode | input | 1 | 1 = master (lines driven), 0 = slave (lines read) |
| pll_lock | input | 1 | Reclocking PLL is locked |
| det_hd | input | 1 | Detector: SMPTE HD stream |
| det_sd | input | 1 | Detector: SMPTE SD stream |
| det_asi | input | 1 | Detector: DVB-ASI stream |
| pin_in | input | 4 | Shared lines as read from the pads ([3] SMPTE, [2] ASI, [1] SD rate, [0] reclock) |
| pin_out | output | 4 | Shared lines as driven in master mode |
| pin_oe | output | 4 | Pad output enables for the shared lines |
| in_data | input | DW | Parallel input word |
| in_valid | input | 1 | Input word valid |
| in_ready | output | 1 | Block can take the input word |
| out_data | output | DW | Gated parallel output word |
| out_valid | output | 1 | Output word valid |
| out_ready | input | 1 | Sink takes the output word |
| locked | output | 1 | Lock status |
| data_err_n | output | 1 | Active-low data error |
| loop_reclk | output | 1 | Loop-through select: 1 reclocked, 0 buffered |

## Verification
The bench goes after slave-mode mismatches that differ in a single bit. A design that compared only some bits would then report lock on a wrong format. It also checks data-through with the detectors showing a SMPTE stream, where a design that still checked the format would drop lock. Mode changes are stepped through cycle by cycle, so a design that drove the format code in the same edge that enables the pads would show a non-zero `pin_out` in that edge. Back-pressure is held for several cycles, so a register that was overwritten or a word that was sent twice shows up as a scoreboard mismatch.

// File: rtl/vlc_pkg.sv
package vlc_pkg;
  localparam int PIN_W    = 4;
  localparam int PIN_SMPT = 3;
  localparam int PIN_ASI  = 2;
  localparam int PIN_RATE = 1;
  localparam int PIN_RC   = 0;

  typedef enum logic [1:0] {
    FMT_NONE = 2'd0,
    FMT_HD   = 2'd1,
    FMT_SD   = 2'd2,
    FMT_ASI  = 2'd3
  } fmt_e;

  // Line code per format: {smpte, asi, sd_rate, reclock}
  function automatic logic [PIN_W-1:0] fmt_code(input fmt_e f);
    logic [PIN_W-1:0] c;
    c = '0;
    case (f)
      FMT_HD:  begin c[PIN_SMPT] = 1'b1; c[PIN_RC] = 1'b1; end
      FMT_SD:  begin c[PIN_SMPT] = 1'b1; c[PIN_RATE] = 1'b1; c[PIN_RC] = 1'b1; end
      FMT_ASI: begin c[PIN_ASI] = 1'b1; c[PIN_RATE] = 1'b1; c[PIN_RC] = 1'b1; end
      default: c = '0;
    endcase
    return c;
  endfunction
endpackage

// File: rtl/vlc_fmt_classify.sv
module vlc_fmt_classify
  import vlc_pkg::*;
(
  input  logic pll_lock,
  input  logic det_hd,
  input  logic det_sd,
  input  logic det_asi,
  output fmt_e fmt
);
  // Priority: HD, then SD, then ASI; nothing without PLL lock
  always_comb begin
    if (!pll_lock)    fmt = FMT_NONE;
    else if (det_hd)  fmt = FMT_HD;
    else if (det_sd)  fmt = FMT_SD;
    else if (det_asi) fmt = FMT_ASI;
    else              fmt = FMT_NONE;
  end
endmodule

// File: rtl/vlc_slave_match.sv
module vlc_slave_match
  import vlc_pkg::*;
(
  input  fmt_e             fmt,
  input  logic [PIN_W-1:0] ctrl,
  output logic             thru,
  output logic             match
);
  logic [PIN_W-1:0] code;
  always_comb begin
    code  = fmt_code(fmt);
    thru  = !ctrl[PIN_SMPT] && !ctrl[PIN_ASI];
    match = (fmt != FMT_NONE) &&
            (ctrl[PIN_SMPT] == code[PIN_SMPT]) &&
            (ctrl[PIN_ASI]  == code[PIN_ASI]) &&
            (ctrl[PIN_RATE] == code[PIN_RATE]);
  end
endmodule

// File: rtl/vlc_status.sv
module vlc_status
  import vlc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             master_mode,
  input  logic             pll_lock,
  input  fmt_e             fmt,
  input  logic             thru,
  input  logic             match,
  input  logic             rc_in,
  output logic             pass,
  output logic             locked,
  output logic             data_err_n,
  output logic             loop_reclk,
  output logic [PIN_W-1:0] pin_out,
  output logic [PIN_W-1:0] pin_oe
);
  logic             mode_q;
  logic             lock_d, err_d, loop_d;
  logic [PIN_W-1:0] code, pout_d;

  always_comb begin
    code = fmt_code(fmt);
    if (!pll_lock) begin
      pass  = 1'b0;
      err_d = 1'b0;
    end else if (master_mode) begin
      pass  = (fmt != FMT_NONE);
      err_d = 1'b1;
    end else begin
      pass  = thru || match;
      err_d = pass;
    end
    lock_d = pass;
    loop_d = master_mode ? code[PIN_RC] : rc_in;
    // Drive the code only once the pads were already enabled last cycle
    pout_d = (master_mode && mode_q) ? code : '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q     <= 1'b0;
      locked     <= 1'b0;
      data_err_n <= 1'b0;
      loop_reclk <= 1'b0;
      pin_out    <= '0;
    end else begin
      mode_q     <= master_mode;
      locked     <= lock_d;
      data_err_n <= err_d;
      loop_reclk <= loop_d;
      pin_out    <= pout_d;
    end
  end

  assign pin_oe = {PIN_W{mode_q}};

  // R2
  oe_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    master_mode |=> (pin_oe == {PIN_W{1'b1}}));
  // R5
  no_pll_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pll_lock |=> (!locked && !data_err_n && pin_out == '0));
  // R10
  pin_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_out != '0) |-> (pin_oe == {PIN_W{1'b1}}));
  // R6
  lock_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    locked |-> data_err_n);
endmodule

// File: rtl/vlc_data_gate.sv
module vlc_data_gate #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pass,
  input  logic [DW-1:0] in_data,
  input  logic          in_valid,
  output logic          in_ready,
  output logic [DW-1:0] out_data,
  output logic          out_valid,
  input  logic          out_ready
);
  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (in_ready) begin
      out_valid <= in_valid;
      if (in_valid) out_data <= pass ? in_data : '0;
    end
  end

  // R11
  hold_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));
  // R11
  no_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);
endmodule

// File: rtl/vid_lock_ctrl.sv
module vid_lock_ctrl
  import vlc_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          master_mode,
  input  logic          pll_lock,
  input  logic          det_hd,
  input  logic          det_sd,
  input  logic          det_asi,
  input  logic [3:0]    pin_in,
  output logic [3:0]    pin_out,
  output logic [3:0]    pin_oe,
  input  logic [DW-1:0] in_data,
  input  logic          in_valid,
  output logic          in_ready,
  output logic [DW-1:0] out_data,
  output logic          out_valid,
  input  logic          out_ready,
  output logic          locked,
  output logic          data_err_n,
  output logic          loop_reclk
);
  fmt_e fmt;
  logic thru, match, pass;

  vlc_fmt_classify u_cls (
    .pll_lock (pll_lock),
    .det_hd   (det_hd),
    .det_sd   (det_sd),
    .det_asi  (det_asi),
    .fmt      (fmt)
  );

  vlc_slave_match u_match (
    .fmt   (fmt),
    .ctrl  (pin_in),
    .thru  (thru),
    .match (match)
  );

  vlc_status u_stat (
    .clk         (clk),
    .rst_n       (rst_n),
    .master_mode (master_mode),
    .pll_lock    (pll_lock),
    .fmt         (fmt),
    .thru        (thru),
    .match       (match),
    .rc_in       (pin_in[PIN_RC]),
    .pass        (pass),
    .locked      (locked),
    .data_err_n  (data_err_n),
    .loop_reclk  (loop_reclk),
    .pin_out     (pin_out),
    .pin_oe      (pin_oe)
  );

  vlc_data_gate #(.DW(DW)) u_gate (
    .clk       (clk),
    .rst_n     (rst_n),
    .pass      (pass),
    .in_data   (in_data),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .out_data  (out_data),
    .out_valid (out_valid),
    .out_ready (out_ready)
  );
endmodule

// File: tb/tb_vid_lock_ctrl.sv
module tb_vid_lock_ctrl;
  localparam int DW = 8;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic master_mode = 1'b0, pll_lock = 1'b0;
  logic det_hd = 1'b0, det_sd = 1'b0, det_asi = 1'b0;
  logic [3:0] pin_in = '0;
  logic [3:0] pin_out, pin_oe;
  logic [DW-1:0] in_data = '0, out_data;
  logic in_valid = 1'b0, in_ready, out_valid, out_ready = 1'b1;
  logic locked, data_err_n, loop_reclk;

  int checks = 0, failures = 0;
  bit done = 1'b0;
  logic [DW-1:0] exp_q[$];

  always #5 clk = ~clk;

  vid_lock_ctrl #(.DW(DW)) dut (
    .clk(clk), .rst_n(rst_n), .master_mode(master_mode), .pll_lock(pll_lock),
    .det_hd(det_hd), .det_sd(det_sd), .det_asi(det_asi), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe), .in_data(in_data), .in_valid(in_valid),
    .in_ready(in_ready), .out_data(out_data), .out_valid(out_valid),
    .out_ready(out_ready), .locked(locked), .data_err_n(data_err_n),
    .loop_reclk(loop_reclk)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Monitor: pops the scoreboard on each output handshake
  always @(negedge clk) begin
    if (rst_n && out_valid && out_ready) begin
      if (exp_q.size() == 0) chk("R11 unexpected word", {24'h0, out_data}, 32'hDEAD);
      else chk("R11 word", {24'h0, out_data}, {24'h0, exp_q.pop_front()});
    end
  end

  // Driver: called at posedge+1; drives one beat and checks status after the edge
  task automatic step(input string req, input bit mm, input bit pl, input bit hd,
                      input bit sd, input bit asi, input logic [3:0] pins,
                      input logic [DW-1:0] d, input bit e_pass, input bit e_lock,
                      input bit e_err, input logic [3:0] e_pout, input bit e_loop);
    #1;
    master_mode = mm; pll_lock = pl; det_hd = hd; det_sd = sd; det_asi = asi;
    pin_in = pins; in_data = d; in_valid = 1'b1; out_ready = 1'b1;
    #1;
    if (in_ready) exp_q.push_back(e_pass ? d : '0);
    @(posedge clk); #1;
    chk({req, " locked"}, {31'h0, locked}, {31'h0, e_lock});
    chk({req, " data_err_n"}, {31'h0, data_err_n}, {31'h0, e_err});
    chk({req, " pin_out"}, {28'h0, pin_out}, {28'h0, e_pout});
    chk({req, " loop_reclk"}, {31'h0, loop_reclk}, {31'h0, e_loop});
    chk("R2 pin_oe", {28'h0, pin_oe}, {28'h0, {4{mm}}});
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] held;
    repeat (3) @(posedge clk);
    #1;
    // R1: reset state
    chk("R1 locked", {31'h0, locked}, 32'h0);
    chk("R1 data_err_n", {31'h0, data_err_n}, 32'h0);
    chk("R1 pin_out", {28'h0, pin_out}, 32'h0);
    chk("R1 pin_oe", {28'h0, pin_oe}, 32'h0);
    chk("R1 out_valid", {31'h0, out_valid}, 32'h0);
    chk("R1 out_data", {24'h0, out_data}, 32'h0);
    chk("R1 loop_reclk", {31'h0, loop_reclk}, 32'h0);
    rst_n = 1'b1;
    @(posedge clk); #1;

    // R5 slave, no PLL lock
    step("R5 slave nolock", 0,0,1,0,0, 4'b1000, 8'hAA, 0,0,0, 4'h0, 0);
    // R6 slave matches
    step("R6 slave HD",  0,1,1,0,0, 4'b1001, 8'h11, 1,1,1, 4'h0, 1);
    step("R6 slave SD",  0,1,0,1,0, 4'b1011, 8'h22, 1,1,1, 4'h0, 1);
    step("R6 slave ASI", 0,1,0,0,1, 4'b0111, 8'h33, 1,1,1, 4'h0, 1);
    // R7 single-bit mismatches
    step("R7 rate bit", 0,1,1,0,0, 4'b1011, 8'h44, 0,0,0, 4'h0, 1);
    step("R7 smpte bit",0,1,0,0,1, 4'b1111, 8'h55, 0,0,0, 4'h0, 1);
    step("R7 asi bit",  0,1,0,1,0, 4'b1110, 8'h56, 0,0,0, 4'h0, 0);
    // R8 data-through, with and without SMPTE detected; R9 loop select from pin
    step("R8 thru none", 0,1,0,0,0, 4'b0000, 8'h66, 1,1,1, 4'h0, 0);
    step("R8 thru hd",   0,1,1,0,0, 4'b0011, 8'h77, 1,1,1, 4'h0, 1);
    step("R9 loop pin",  0,1,0,0,0, 4'b0001, 8'h78, 1,1,1, 4'h0, 1);
    // R10 entry to master: first edge enables pads with lines quiet
    step("R10 enter",  1,1,1,0,0, 4'b0000, 8'h88, 1,1,1, 4'h0, 1);
    step("R3 HD",      1,1,1,0,0, 4'b0000, 8'h89, 1,1,1, 4'b1001, 1);
    step("R3 SD",      1,1,0,1,0, 4'b1111, 8'h8A, 1,1,1, 4'b1011, 1);
    step("R3 ASI",     1,1,0,0,1, 4'b0000, 8'h8B, 1,1,1, 4'b0111, 1);
    step("R3 priority",1,1,1,1,1, 4'b0000, 8'h8C, 1,1,1, 4'b1001, 1);
    step("R4 none",    1,1,0,0,0, 4'b1111, 8'h8D, 0,0,1, 4'h0, 0);
    step("R5 master nolock", 1,0,1,0,0, 4'b0000, 8'h8E, 0,0,0, 4'h0, 0);
    step("R3 relock",  1,1,0,1,0, 4'b0000, 8'h8F, 1,1,1, 4'b1011, 1);
    // back to slave: pads released, lines quiet
    step("R9 exit",    0,1,1,0,0, 4'b1001, 8'h90, 1,1,1, 4'h0, 1);

    // R11 back-pressure
    #1;
    out_ready = 1'b0; in_valid = 1'b0;
    @(posedge clk); #1;
    held = out_data;
    in_valid = 1'b1; in_data = 8'h5C;
    #1;
    chk("R11 in_ready low", {31'h0, in_ready}, 32'h0);
    for (int i = 0; i < 4; i++) begin
      @(posedge clk); #1;
      chk("R11 out_valid hold", {31'h0, out_valid}, 32'h1);
      chk("R11 out_data hold", {24'h0, out_data}, {24'h0, held});
    end
    exp_q.push_back(8'h5C);
    out_ready = 1'b1;
    @(posedge clk); #1;
    in_valid = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    chk("R11 drained", exp_q.size(), 32'h0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule